// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block divides a fast input clock by a 17-bit programmable ratio using the pulse-swallow method. The ratio is split into a 13-bit main count M and a 4-bit swallow count A. These two counts steer a dual-modulus prescaler that divides by 16 or 17. In each division period the prescaler runs at 17 for A of its output ticks and at 16 for the other M-A ticks. One period therefore lasts 16*M + A input clocks. At the end of every period the block emits a single-clock pulse, which feeds a phase/frequency comparator.

A ratio enters through a write strobe and is held in a shadow register. The working counters take the shadow value only at the end of a division period, so a retune never cuts a period short and never stretches one. A write that breaks the pulse-swallow constraint is refused and flagged, and the previous ratio keeps running. For test observation, a half-rate copy of the period pulse can be routed to a pin.

Top module: `pswDivider`

## Requirements
- R1: The synchronous active-low reset clears the shadow and working state and drives `divPulse`, `testOut`, `modHigh` and `ratioErr` low. No pulse appears until a valid ratio has been written.
- R2: `ratioIn[16:4]` is the main count M and `ratioIn[3:0]` is the swallow count A. Once a ratio is running, pulses are exactly 16*M + A input clocks apart.
- R3: `divPulse` is high for exactly one input clock per division period.
- R4: A written ratio is valid when M >= 1 and M >= A. An invalid write leaves the shadow ratio unchanged. `ratioErr` reads 1 from the clock after an invalid write, reads 0 from the clock after a valid write, and otherwise holds its value.
- R5: A valid write made during a period does not change that period. The new ratio governs the period that starts at the next pulse. The shadow value is sampled at the load edge, so a write captured on that same edge applies one period later.
- R6: After reset, the first valid write captured on edge W loads the counters on edge W+1. The first pulse is then visible after edge W+1+16*M+A.
- R7: `modHigh` (divide-by-17 select) is high for the first 17*A clocks of each period and low for the remaining 16*(M-A) clocks.
- R8: `testOut` equals `testMode` AND a half-rate bit. That bit is 0 after reset and toggles on the edge that raises each `divPulse`.
- R9: The boundary ratios work: M=1,A=0 (16 clocks), M=1,A=1 (17 clocks), and A=M (whole period at divide-by-17).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock being divided |
| rstN | input | 1 | Synchronous active-low reset |
| writeEn | input | 1 | Captures `ratioIn` into the shadow register when valid |
| ratioIn | input | 17 | {M[12:0], A[3:0]} |
| testMode | input | 1 | Routes the half-rate pulse copy to `testOut` |
| divPulse | output | 1 | One-clock pulse at the end of each period |
| testOut | output | 1 | Half-rate pulse copy, gated by `testMode` |
| modHigh | output | 1 | Prescaler modulus select, 1 = divide by 17 |
| ratioErr | output | 1 | Last write was rejected |

## Verification
On every cycle, the bound assertions check the following:
- `divPulse` is one clock wide and stays quiet while idle.
- `testOut` is gated by `testMode` and flips with each pulse.
- `ratioErr` follows the validity of each write and holds between writes.
- `modHigh` rises only at a period boundary.

Exact period lengths, the cycle on which a retune takes effect, the idle-to-first-pulse latency and the 17*A length of the divide-by-17 phase need a reference count over whole periods. Only the bench's cycle-exact model of the ratio sequence can show those.

// File: rtl/pswDivPkg.sv
package pswDivPkg;
  // strobes from control to datapath
  typedef struct packed {
    logic load;   // copy shadow ratio into working counters, clear prescaler phase
    logic tick;   // prescaler output edge: step main and swallow counts
  } ctrlStrobe_t;
endpackage

// File: rtl/pswDivDatapath.sv
module pswDivDatapath
  import pswDivPkg::*;
#(
  parameter int MAIN_W = 13,
  parameter int SWAL_W = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       writeEn,
  input  logic [MAIN_W+SWAL_W-1:0]   ratioIn,
  input  ctrlStrobe_t                strobe,
  output logic                       mZero,
  output logic                       mOne,
  output logic                       aZero,
  output logic                       pcLowEnd,
  output logic                       pcHighEnd,
  output logic                       shadowLive,
  output logic                       ratioErr
);
  localparam int RATIO_W = MAIN_W + SWAL_W;
  localparam int PC_W    = SWAL_W + 1;
  localparam int NDIV    = 1 << SWAL_W;

  logic [MAIN_W-1:0] inM, shM, mLeft;
  logic [SWAL_W-1:0] inA, shA, aLeft;
  logic [PC_W-1:0]   pc;
  logic              inValid;

  assign inM     = ratioIn[RATIO_W-1:SWAL_W];
  assign inA     = ratioIn[SWAL_W-1:0];
  assign inValid = (inM != '0) && (inM >= MAIN_W'(inA));

  // shadow ratio, only ever holds a valid pair or zero
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shM      <= '0;
      shA      <= '0;
      ratioErr <= 1'b0;
    end else if (writeEn) begin
      ratioErr <= !inValid;
      if (inValid) begin
        shM <= inM;
        shA <= inA;
      end
    end
  end

  // working counters and prescaler phase
  always_ff @(posedge clk) begin
    if (!rstN) begin
      mLeft <= '0;
      aLeft <= '0;
      pc    <= '0;
    end else if (strobe.load) begin
      mLeft <= shM;
      aLeft <= shA;
      pc    <= '0;
    end else if (strobe.tick) begin
      pc    <= '0;
      mLeft <= mLeft - MAIN_W'(1);
      if (aLeft != '0) aLeft <= aLeft - SWAL_W'(1);
    end else if (mLeft != '0) begin
      pc <= pc + PC_W'(1);
    end
  end

  assign mZero      = (mLeft == '0);
  assign mOne       = (mLeft == MAIN_W'(1));
  assign aZero      = (aLeft == '0);
  assign pcLowEnd   = (pc == PC_W'(NDIV - 1));
  assign pcHighEnd  = (pc == PC_W'(NDIV));
  assign shadowLive = (shM != '0);
endmodule

// File: rtl/pswDivControl.sv
module pswDivControl
  import pswDivPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        testMode,
  input  logic        mZero,
  input  logic        mOne,
  input  logic        aZero,
  input  logic        pcLowEnd,
  input  logic        pcHighEnd,
  input  logic        shadowLive,
  output ctrlStrobe_t strobe,
  output logic        modHigh,
  output logic        divPulse,
  output logic        testOut
);
  logic preEnd, cycleEnd, halfQ;

  assign modHigh  = !aZero;
  assign preEnd   = !mZero && (modHigh ? pcHighEnd : pcLowEnd);
  assign cycleEnd = preEnd && mOne;

  always_comb begin
    strobe.load = cycleEnd || (mZero && shadowLive);
    strobe.tick = preEnd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divPulse <= 1'b0;
      halfQ    <= 1'b0;
    end else begin
      divPulse <= cycleEnd;
      if (cycleEnd) halfQ <= !halfQ;
    end
  end

  assign testOut = testMode && halfQ;
endmodule

// File: rtl/pswDivider.sv
module pswDivider
  import pswDivPkg::*;
#(
  parameter int MAIN_W = 13,
  parameter int SWAL_W = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     writeEn,
  input  logic [MAIN_W+SWAL_W-1:0] ratioIn,
  input  logic                     testMode,
  output logic                     divPulse,
  output logic                     testOut,
  output logic                     modHigh,
  output logic                     ratioErr
);
  ctrlStrobe_t strobe;
  logic mZero, mOne, aZero, pcLowEnd, pcHighEnd, shadowLive;

  pswDivDatapath #(.MAIN_W(MAIN_W), .SWAL_W(SWAL_W)) dp (
    .clk(clk), .rstN(rstN), .writeEn(writeEn), .ratioIn(ratioIn),
    .strobe(strobe), .mZero(mZero), .mOne(mOne), .aZero(aZero),
    .pcLowEnd(pcLowEnd), .pcHighEnd(pcHighEnd),
    .shadowLive(shadowLive), .ratioErr(ratioErr)
  );

  pswDivControl ctl (
    .clk(clk), .rstN(rstN), .testMode(testMode), .mZero(mZero),
    .mOne(mOne), .aZero(aZero), .pcLowEnd(pcLowEnd),
    .pcHighEnd(pcHighEnd), .shadowLive(shadowLive), .strobe(strobe),
    .modHigh(modHigh), .divPulse(divPulse), .testOut(testOut)
  );
endmodule

// File: rtl/pswDivChecker.sv
module pswDivChecker #(
  parameter int MAIN_W = 13,
  parameter int SWAL_W = 4
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     writeEn,
  input logic [MAIN_W+SWAL_W-1:0] ratioIn,
  input logic                     testMode,
  input logic                     divPulse,
  input logic                     testOut,
  input logic                     modHigh,
  input logic                     ratioErr,
  input logic                     idleNow
);
  logic [MAIN_W-1:0] wrM;
  logic [SWAL_W-1:0] wrA;
  logic              wrOk;
  assign wrM  = ratioIn[MAIN_W+SWAL_W-1:SWAL_W];
  assign wrA  = ratioIn[SWAL_W-1:0];
  assign wrOk = (wrM != '0) && (wrM >= MAIN_W'(wrA));

  p_pulse_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    divPulse |=> !divPulse);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    idleNow |-> !divPulse);

  p_test_gate_r8: assert property (@(posedge clk) disable iff (!rstN)
    !testMode |-> !testOut);

  p_half_toggle_r8: assert property (@(posedge clk) disable iff (!rstN)
    (testMode && $past(testMode) && divPulse) |-> (testOut != $past(testOut)));

  p_err_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    (writeEn && wrOk) |=> !ratioErr);

  p_err_set_r4: assert property (@(posedge clk) disable iff (!rstN)
    (writeEn && !wrOk) |=> ratioErr);

  p_err_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !writeEn |=> $stable(ratioErr));

  p_mod_rise_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(modHigh) |-> (divPulse || $past(idleNow)));
endmodule

bind pswDivider pswDivChecker #(.MAIN_W(MAIN_W), .SWAL_W(SWAL_W)) chk (
  .clk(clk), .rstN(rstN), .writeEn(writeEn), .ratioIn(ratioIn),
  .testMode(testMode), .divPulse(divPulse), .testOut(testOut),
  .modHigh(modHigh), .ratioErr(ratioErr), .idleNow(mZero)
);

// File: tb/pswDivider_test.sv
`timescale 1ns/1ps
module pswDivider_test;
  localparam int TOTAL = 70000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        writeEn = 1'b0;
  logic [16:0] ratioIn = '0;
  logic        testMode = 1'b0;
  logic        divPulse, testOut, modHigh, ratioErr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  pswDivider uut (
    .clk(clk), .rstN(rstN), .writeEn(writeEn), .ratioIn(ratioIn),
    .testMode(testMode), .divPulse(divPulse), .testOut(testOut),
    .modHigh(modHigh), .ratioErr(ratioErr)
  );

  always #2.5 clk = ~clk;

  function automatic bit isValid(input logic [16:0] r);
    return (r[16:4] != 0) && (r[16:4] >= {9'd0, r[3:0]});
  endfunction

  function automatic int periodOf(input logic [16:0] r);
    return 16 * int'(r[16:4]) + int'(r[3:0]);
  endfunction

  function automatic logic [16:0] mk(input int m, input int a);
    return {13'(m), 4'(a)};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finishRun();
  end

  // bench model state
  logic [16:0] sBench, sBefore, pendV;
  bit   pendW, idle, halfB, wantPulse, expMod;
  int   nextPulse, loadK, aCyc, firstWriteK, firstPulseK;

  initial begin
    void'($urandom(32'd4242));
    sBench = '0; pendW = 0; pendV = '0; idle = 1; halfB = 0;
    nextPulse = -1; loadK = 0; aCyc = 0; firstWriteK = -1; firstPulseK = -1;
    testMode = 1'b1;
    repeat (4) @(negedge clk);
    // R1: outputs held low under reset
    check(divPulse == 0, "R1 divPulse in reset", int'(divPulse), 0);
    check(testOut == 0,  "R1 testOut in reset", int'(testOut), 0);
    check(modHigh == 0,  "R1 modHigh in reset", int'(modHigh), 0);
    check(ratioErr == 0, "R1 ratioErr in reset", int'(ratioErr), 0);
    rstN = 1'b1;
    for (int k = 1; k <= TOTAL; k++) begin
      @(negedge clk);
      sBefore = sBench;
      if (pendW) begin
        check(ratioErr == !isValid(pendV), "R4 ratioErr after write",
              int'(ratioErr), int'(!isValid(pendV)));
        if (isValid(pendV)) sBench = pendV;
      end
      pendW = 0;

      wantPulse = !idle && (k == nextPulse);
      // R2 R3 R5 R9: exact pulse placement every clock
      check(divPulse == wantPulse, "R2/R3/R5/R9 divPulse", int'(divPulse), int'(wantPulse));
      if (wantPulse) begin
        halfB = !halfB;
        if (firstPulseK < 0) begin
          firstPulseK = k;
          // R6: first pulse latency from idle
          check(k == firstWriteK + 2 + 16, "R6 first pulse cycle", k, firstWriteK + 2 + 16);
        end
      end
      if (wantPulse || (idle && sBefore != 0)) begin
        loadK = k; aCyc = int'(sBefore[3:0]);
        nextPulse = k + periodOf(sBefore);
        idle = 0;
      end
      expMod = !idle && ((k - loadK) < 17 * aCyc);
      check(modHigh == expMod, "R7 modHigh", int'(modHigh), int'(expMod));
      check(testOut == (testMode & halfB), "R8 testOut", int'(testOut), int'(testMode & halfB));
      if (idle) check(divPulse == 0, "R1 idle quiet", int'(divPulse), 0);

      // stimulus
      writeEn = 1'b0;
      case (k)
        10:    begin writeEn = 1; ratioIn = mk(1, 0); firstWriteK = k; end  // R9 minimum 16
        300:   begin writeEn = 1; ratioIn = mk(1, 1); end                   // R9 17
        600:   begin writeEn = 1; ratioIn = mk(15, 15); end                 // R9 A=M
        1500:  begin writeEn = 1; ratioIn = mk(3, 7); end                   // R4 M<A
        2200:  begin writeEn = 1; ratioIn = mk(0, 0); end                   // R4 M=0
        2800:  begin writeEn = 1; ratioIn = mk(20, 5); end                  // R4 clears
        3100:  testMode = 1'b0;
        3600:  testMode = 1'b1;
        default: begin
          if (k > 4000 && $urandom_range(0, 149) == 0) begin
            writeEn = 1;
            ratioIn = mk($urandom_range(0, 40), $urandom_range(0, 15));
          end
          if (k > 4000 && $urandom_range(0, 2999) == 0) testMode = !testMode;
        end
      endcase
      if (writeEn) begin pendW = 1; pendV = ratioIn; end
    end
    check(firstPulseK > 0, "R6 pulse seen", firstPulseK, 1);
    finishRun();
  end
endmodule